// File: doc/BRIEF.md
# Open-Drain Display Channel Line Controller

This block is one memory-mapped register that software uses to bit-bang the clock and data wires of a monitor's display data channel. For each wire the register holds a level bit and a drive-enable bit. The block turns these into open-drain pad controls. A wire is pulled low only while its enable is set and its level bit is 0. In every other case the pad is released and an external pull-up holds the wire high. The real wire levels pass through a two-flop synchroniser and are read back in separate read-only bit positions of the same register.

Two variants come from parameters. In the plain variant, every write to the register moves the pads. In the gated variant, the field positions shift up by one bit, and a mask bit must be set before the pads follow the register. Even then, only writes of certain byte lanes move the pads. This stops a driver that writes the register one byte at a time from causing glitches on the bus while the register is half written.

Top module: `ddc_gpio`

## Requirements
- R1: After reset all stored bits are 0, both pad enables are low (wires released), and the read value shows only the two input bits, which read 1 while the wires are idle high.
- R2: At a pad update, a pad is driven low (its `*Oe` output is 1) exactly when the stored enable bit of its wire is 1 and the stored level bit is 0.
- R3: A wire whose stored enable bit is 0 is released after an update, even when its level bit is 0.
- R4: With base index b (parameter `BASE_BIT`), the data level is bit b, the clock level is bit b+1, the data enable is bit b+16 and the clock enable is bit b+17. For b=0: bits 0, 1, 16, 17. For b=1: bits 1, 2, 17, 18.
- R5: The data-wire input reads back in bit b+8 and the clock-wire input in bit b+9. Each input bit follows its wire through two flops: a change is not visible after one rising edge and is visible after two. Write data aimed at the input bits is ignored. Every bit that is neither a writable field nor an input bit reads 0.
- R6: Plain variant (`GATED`=0): every write updates both pads.
- R7: Gated variant (`GATED`=1): the mask bit is bit 25 and is writable. The pads update only on a write after which bit 25 is 1 and either byte lane 2 is written, or byte lane 0 is written while at least one enable bit is 1.
- R8: Between updates the pad controls hold their values, whatever the stored bits become.
- R9: A write stores only the byte lanes whose `byteEn` bit is set. The other lanes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| byteEn | input | 4 | Byte lanes taking part in the write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Register read value, including synchronised input bits |
| sdaIn | input | 1 | Level seen on the data wire |
| sclIn | input | 1 | Level seen on the clock wire |
| sdaOe | output | 1 | 1 pulls the data wire low, 0 releases it |
| sclOe | output | 1 | 1 pulls the clock wire low, 0 releases it |

## Verification
The bench builds two copies side by side: a plain copy with base index 0 and a gated copy with base index 1 and mask bit 25, both with a two-stage synchroniser. The plain copy covers the drive rule, lane merging, ignored input-bit writes and the one-edge versus two-edge latency. It does this with wires pulled low from outside, which the bench models. The gated copy lets byte-0, byte-2 and byte-3 writes be sequenced so that stored bits and pad state differ. This shows that the pads move only when the gating rule allows it.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;
  localparam int REG_W = 32;
  localparam int LANES = REG_W / 8;

  typedef struct packed {
    logic [LANES-1:0] laneWr;
    logic             padUpdate;
  } ddcStrobe_t;

  function automatic logic [REG_W-1:0] bitAt(input int idx);
    return REG_W'(1) << idx;
  endfunction
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stg[s] <= '1;
      else if (s == 0) stg[s] <= din;
      else stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ddc_gpio_ctrl.sv
module ddc_gpio_ctrl
  import ddc_gpio_pkg::*;
#(
  parameter int BASE_BIT = 0,
  parameter int GATED    = 0,
  parameter int GATE_BIT = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [LANES-1:0] byteEn,
  input  logic [2:0]       ctlWr,   // {gate, sclEn, sdaEn} from write data
  input  logic [2:0]       ctlCur,  // same bits from the stored register
  output ddcStrobe_t       strobe
);
  localparam int SDA_EN_LANE = (BASE_BIT + 16) / 8;
  localparam int SCL_EN_LANE = (BASE_BIT + 17) / 8;
  localparam int GATE_LANE   = GATE_BIT / 8;

  logic mSdaEn, mSclEn, mGate, gatedOk;

  // value of each control bit once the write lands
  assign mSdaEn = byteEn[SDA_EN_LANE] ? ctlWr[0] : ctlCur[0];
  assign mSclEn = byteEn[SCL_EN_LANE] ? ctlWr[1] : ctlCur[1];
  assign mGate  = byteEn[GATE_LANE]   ? ctlWr[2] : ctlCur[2];

  assign gatedOk = mGate && (byteEn[SDA_EN_LANE] || (byteEn[0] && (mSdaEn || mSclEn)));

  assign strobe.laneWr    = wrEn ? byteEn : '0;
  assign strobe.padUpdate = wrEn && ((GATED == 0) || gatedOk);

  // R8
  upd_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !strobe.padUpdate);

  if (GATED == 0) begin : gPlainChk
    // R6
    plain_always_updates_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrEn |-> strobe.padUpdate);
  end else begin : gGatedChk
    // R7
    gated_lane_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !byteEn[0] && !byteEn[SDA_EN_LANE]) |-> !strobe.padUpdate);
  end
endmodule

// File: rtl/ddc_gpio_datapath.sv
module ddc_gpio_datapath
  import ddc_gpio_pkg::*;
#(
  parameter int BASE_BIT    = 0,
  parameter int GATED       = 0,
  parameter int GATE_BIT    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ddcStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic             sdaIn,
  input  logic             sclIn,
  output logic [REG_W-1:0] storeQ,
  output logic [REG_W-1:0] rdData,
  output logic             sdaOe,
  output logic             sclOe
);
  localparam int SDA_OUT = BASE_BIT;
  localparam int SCL_OUT = BASE_BIT + 1;
  localparam int SDA_IN  = BASE_BIT + 8;
  localparam int SCL_IN  = BASE_BIT + 9;
  localparam int SDA_EN  = BASE_BIT + 16;
  localparam int SCL_EN  = BASE_BIT + 17;
  localparam logic [REG_W-1:0] WR_MASK =
    bitAt(SDA_OUT) | bitAt(SCL_OUT) | bitAt(SDA_EN) | bitAt(SCL_EN) |
    ((GATED != 0) ? bitAt(GATE_BIT) : '0);

  logic [REG_W-1:0] storeR, nextStore;
  logic             sdaOeR, sclOeR;
  logic [1:0]       lineSync;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign nextStore[l*8 +: 8] = strobe.laneWr[l] ? (wrData[l*8 +: 8] & WR_MASK[l*8 +: 8])
                                                  : storeR[l*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) storeR <= '0;
    else storeR <= nextStore;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOeR <= 1'b0;
      sclOeR <= 1'b0;
    end else if (strobe.padUpdate) begin
      sdaOeR <= nextStore[SDA_EN] & ~nextStore[SDA_OUT];
      sclOeR <= nextStore[SCL_EN] & ~nextStore[SCL_OUT];
    end
  end

  ddc_sync #(.STAGES(SYNC_STAGES), .W(2)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({sclIn, sdaIn}),
    .dout(lineSync)
  );

  assign storeQ = storeR;
  assign rdData = storeR | (REG_W'(lineSync[0]) << SDA_IN) | (REG_W'(lineSync[1]) << SCL_IN);
  assign sdaOe  = sdaOeR;
  assign sclOe  = sclOeR;

  // R8
  pads_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.padUpdate |=> $stable({sdaOeR, sclOeR}));

  // R2
  drive_from_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOeR) || $rose(sclOeR)) |-> $past(strobe.padUpdate));
endmodule

// File: rtl/ddc_gpio.sv
module ddc_gpio
  import ddc_gpio_pkg::*;
#(
  parameter int BASE_BIT    = 0,
  parameter int GATED       = 0,
  parameter int GATE_BIT    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  byteEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        sdaIn,
  input  logic        sclIn,
  output logic        sdaOe,
  output logic        sclOe
);
  localparam int SDA_EN = BASE_BIT + 16;
  localparam int SCL_EN = BASE_BIT + 17;
  localparam logic [REG_W-1:0] VIS_MASK =
    bitAt(BASE_BIT) | bitAt(BASE_BIT + 1) | bitAt(BASE_BIT + 8) | bitAt(BASE_BIT + 9) |
    bitAt(SDA_EN) | bitAt(SCL_EN) | ((GATED != 0) ? bitAt(GATE_BIT) : '0);

  ddcStrobe_t       strobe;
  logic [REG_W-1:0] storeQ;

  ddc_gpio_ctrl #(.BASE_BIT(BASE_BIT), .GATED(GATED), .GATE_BIT(GATE_BIT)) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .byteEn(byteEn),
    .ctlWr ({wrData[GATE_BIT], wrData[SCL_EN], wrData[SDA_EN]}),
    .ctlCur({storeQ[GATE_BIT], storeQ[SCL_EN], storeQ[SDA_EN]}),
    .strobe(strobe)
  );

  ddc_gpio_datapath #(.BASE_BIT(BASE_BIT), .GATED(GATED), .GATE_BIT(GATE_BIT),
                      .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .sdaIn (sdaIn),
    .sclIn (sclIn),
    .storeQ(storeQ),
    .rdData(rdData),
    .sdaOe (sdaOe),
    .sclOe (sclOe)
  );

  // R5
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~VIS_MASK) == '0);
endmodule

// File: tb/test_ddc_gpio.sv
`timescale 1ns/1ps
module test_ddc_gpio;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        wrEnP = 0, wrEnG = 0;
  logic [3:0]  beP = 0, beG = 0;
  logic [31:0] wdP = 0, wdG = 0, rdP, rdG;
  logic        sdaOeP, sclOeP, sdaOeG, sclOeG;
  logic        extSdaLowP = 0, extSclLowP = 0;
  logic        sdaLineP, sclLineP, sdaLineG, sclLineG;

  // open-drain wires with pull-up; bench can also pull a wire low from outside
  assign sdaLineP = ~(sdaOeP | extSdaLowP);
  assign sclLineP = ~(sclOeP | extSclLowP);
  assign sdaLineG = ~sdaOeG;
  assign sclLineG = ~sclOeG;

  ddc_gpio #(.BASE_BIT(0), .GATED(0)) i_ddc_gpio_b0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEnP), .byteEn(beP), .wrData(wdP), .rdData(rdP),
    .sdaIn(sdaLineP), .sclIn(sclLineP), .sdaOe(sdaOeP), .sclOe(sclOeP));

  ddc_gpio #(.BASE_BIT(1), .GATED(1), .GATE_BIT(25)) i_ddc_gpio (
    .clk(clk), .rstN(rstN), .wrEn(wrEnG), .byteEn(beG), .wrData(wdG), .rdData(rdG),
    .sdaIn(sdaLineG), .sclIn(sclLineG), .sdaOe(sdaOeG), .sclOe(sclOeG));

  typedef struct {
    string       tag;
    bit          gSel;
    logic [31:0] rd;
    logic        sOe;
    logic        cOe;
  } expItem_t;

  expItem_t q[$];
  event     sampleEv;
  int       nRun = 0, nFail = 0;
  bit       done = 0;

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        expItem_t it;
        logic [31:0] aRd;
        logic aS, aC;
        it = q.pop_front();
        aRd = it.gSel ? rdG : rdP;
        aS  = it.gSel ? sdaOeG : sdaOeP;
        aC  = it.gSel ? sclOeG : sclOeP;
        nRun++;
        if (aRd !== it.rd || aS !== it.sOe || aC !== it.cOe) begin
          nFail++;
          $display("FAIL %s: actual rd=%08h sdaOe=%b sclOe=%b expected rd=%08h sdaOe=%b sclOe=%b",
                   it.tag, aRd, aS, aC, it.rd, it.sOe, it.cOe);
        end
      end
    end
  end

  task automatic expectNow(input string tag, input bit gSel, input logic [31:0] rd,
                           input logic sOe, input logic cOe);
    expItem_t it;
    it.tag = tag; it.gSel = gSel; it.rd = rd; it.sOe = sOe; it.cOe = cOe;
    q.push_back(it);
    -> sampleEv;
    #1;
  endtask

  task automatic writeReg(input bit gSel, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    if (gSel) begin wrEnG = 1; wdG = d; beG = be; end
    else      begin wrEnP = 1; wdP = d; beP = be; end
    @(negedge clk);
    wrEnG = 0; wrEnP = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    expectNow("R1 reset plain", 0, 32'h0000_0300, 0, 0);
    expectNow("R1 reset gated", 1, 32'h0000_0600, 0, 0);

    // plain variant, b=0
    writeReg(0, 32'h0003_0000, 4'hF); settle();
    expectNow("R2 R4 both driven low", 0, 32'h0003_0000, 1, 1);
    writeReg(0, 32'h0001_0002, 4'hF); settle();
    expectNow("R2 R5 sda low scl released", 0, 32'h0001_0202, 1, 0);
    writeReg(0, 32'h0000_0000, 4'hF); settle();
    expectNow("R3 enable clear releases", 0, 32'h0000_0300, 0, 0);
    writeReg(0, 32'hFFFC_FCFC, 4'hF);
    expectNow("R5 input and spare bits not writable", 0, 32'h0000_0300, 0, 0);

    @(negedge clk); extSclLowP = 1;
    @(negedge clk);
    expectNow("R5 one edge not yet visible", 0, 32'h0000_0300, 0, 0);
    @(negedge clk);
    expectNow("R5 visible after two edges", 0, 32'h0000_0100, 0, 0);
    extSclLowP = 1'b0; extSdaLowP = 1'b1; settle();
    expectNow("R5 sda input position", 0, 32'h0000_0200, 0, 0);
    extSdaLowP = 1'b0; settle();

    writeReg(0, 32'h0000_0003, 4'b0001);
    expectNow("R9 lane0 only", 0, 32'h0000_0303, 0, 0);
    writeReg(0, 32'h0001_0000, 4'b0100);
    expectNow("R9 R6 lane2 merge keeps lane0", 0, 32'h0001_0303, 0, 0);
    writeReg(0, 32'h0000_0000, 4'b0001); settle();
    expectNow("R6 lane0 write updates", 0, 32'h0001_0200, 1, 0);

    // gated variant, b=1, mask bit 25
    writeReg(1, 32'h0006_0000, 4'hF);
    expectNow("R7 mask clear no update", 1, 32'h0006_0600, 0, 0);
    writeReg(1, 32'h0206_0000, 4'hF); settle();
    expectNow("R7 R4 lane2 with mask updates", 1, 32'h0206_0000, 1, 1);
    writeReg(1, 32'h0000_0004, 4'b0001); settle();
    expectNow("R7 lane0 with enables updates", 1, 32'h0206_0404, 1, 0);
    writeReg(1, 32'h0000_0000, 4'b1000);
    expectNow("R7 lane3 no update", 1, 32'h0006_0404, 1, 0);
    writeReg(1, 32'h0000_0000, 4'b0001);
    expectNow("R8 mask clear lane0 holds pads", 1, 32'h0006_0400, 1, 0);
    writeReg(1, 32'h0200_0000, 4'b1000);
    expectNow("R8 mask set by lane3 holds pads", 1, 32'h0206_0400, 1, 0);
    writeReg(1, 32'h0000_0000, 4'b0001); settle();
    expectNow("R7 lane0 after mask set updates", 1, 32'h0206_0000, 1, 1);
    writeReg(1, 32'h0000_0000, 4'b1000);
    writeReg(1, 32'h0000_0000, 4'b0100);
    expectNow("R8 enables cleared without update", 1, 32'h0000_0000, 1, 1);
    writeReg(1, 32'h0200_0000, 4'b1000);
    writeReg(1, 32'h0000_0002, 4'b0001);
    expectNow("R7 lane0 with enables clear no update", 1, 32'h0200_0002, 1, 1);
    writeReg(1, 32'h0006_0000, 4'b0100); settle();
    expectNow("R7 R2 lane2 update", 1, 32'h0206_0202, 0, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule